// File: doc/BRIEF.md
# ADC Result Register Bank with Read-Clear Flags

This block holds the most recent 10-bit conversion result for each of a configurable number of analog channels. A CPU sees each result as two byte-wide, read-only registers. A converter delivers each new result as a one-cycle write pulse that carries a channel index. Each channel also keeps two status bits. The "new data" bit shows that a result has arrived that software has not yet picked up. The "lost data" bit shows that a result was replaced before software had read both bytes of it.

The read side uses a channel index, a byte-select bit (0 selects the low byte, 1 selects the high byte) and a valid strobe. Read data is combinational from the selected channel, so a read returns the flag values as they were before that read clears them. Side effects apply on the clock edge at which the strobe is high. Reading the low byte consumes both status bits. Each channel remembers which of its two bytes has been read since its last write, and it uses this record to judge overrun at the next write.

Top module: `adcr_result_bank`

## Requirements
- R1: When the high byte (select = 1) is selected, read data bits 7..0 equal result bits 9..2 of the selected channel.
- R2: When the low byte (select = 0) is selected, read data bits 7..6 equal result bits 1..0, and bits 5..2 read as 0.
- R3: A write pulse stores its data as the channel's new result and sets that channel's new-data flag, which is low-byte bit 0.
- R4: A valid low-byte read clears the channel's new-data flag on that clock edge. If a write to the same channel falls in the same cycle, the write wins and the flag ends at 1.
- R5: A write sets the lost-data flag (low-byte bit 1) if either byte of the channel was not read between the previous write and this one. A write that follows both byte reads leaves the flag at 0. After reset, both bytes count as already read.
- R6: A valid low-byte read clears the lost-data flag. If a write to the same channel falls in the same cycle, the flag is judged from the read history before that cycle, and the low read in that cycle does not count towards it.
- R7: Read data shows the selected byte, flags included, as it stood before the clearing effects of the current read.
- R8: After reset, every result byte and every flag of every channel reads 0.
- R9: Writes and reads that target one channel leave every other channel's result and flags unchanged.
- R10: With the valid strobe low, a selected byte can be shown without any effect on flags or read history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnv_valid | input | 1 | One-cycle pulse carrying a new conversion result |
| cnv_chan | input | CH_W | Channel that the result belongs to |
| cnv_data | input | RES_W | Conversion result |
| rd_en | input | 1 | Read strobe; side effects apply at the edge where it is high |
| rd_chan | input | CH_W | Channel selected for reading |
| rd_hi | input | 1 | Byte select: 0 low byte with flags, 1 high byte |
| rd_data | output | 8 | Combinational read data of the selected byte |

## Verification
A converter write and a CPU read of the same channel can land in the same cycle. The case of most interest is a write together with a low-byte read, because there the write must win the new-data flag and overrun must be judged from the read history before that cycle. The bench enumerates every sequence of three operations taken from idle, write, low read, high read, write with low read and write with high read, each aimed at either channel of a two-channel build. After every sequence it reads back both bytes of both channels. An arithmetic model, kept separately in the bench, predicts every returned byte.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

    localparam int BYTE_W = 8;

    // Per-channel status and read history.
    typedef struct packed {
        logic fresh;     // new result waiting to be read
        logic lost;      // previous result overwritten before fully read
        logic lo_seen;   // low byte read since last write
        logic hi_seen;   // high byte read since last write
    } adcr_flags_t;

    localparam adcr_flags_t FLAGS_RESET = '{fresh: 1'b0, lost: 1'b0,
                                           lo_seen: 1'b1, hi_seen: 1'b1};

endpackage

// File: rtl/adcr_decode.sv
module adcr_decode #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1
) (
    input  logic              cnv_valid,
    input  logic [CH_W-1:0]   cnv_chan,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic              rd_hi,
    output logic [NUM_CH-1:0] wr_sel,
    output logic [NUM_CH-1:0] rd_lo_sel,
    output logic [NUM_CH-1:0] rd_hi_sel
);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        logic wr_hit;
        logic rd_hit;
        assign wr_hit       = (cnv_chan == CH_W'(g));
        assign rd_hit       = (rd_chan  == CH_W'(g));
        assign wr_sel[g]    = cnv_valid & wr_hit;
        assign rd_lo_sel[g] = rd_en & rd_hit & ~rd_hi;
        assign rd_hi_sel[g] = rd_en & rd_hit &  rd_hi;
    end

endmodule

// File: rtl/adcr_chan.sv
module adcr_chan
    import adcr_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RES_W-1:0] wr_data,
    input  logic             rd_lo_en,
    input  logic             rd_hi_en,
    output logic [RES_W-1:0] res_q,
    output adcr_flags_t      flags_q
);

    typedef struct packed {
        logic [RES_W-1:0] res;
        adcr_flags_t      fl;
    } chan_state_t;

    chan_state_t st_d;
    chan_state_t st_q;

    always_comb begin
        st_d = st_q;
        // Read side effects first; a same-cycle write overrides them.
        if (rd_lo_en) begin
            st_d.fl.fresh   = 1'b0;
            st_d.fl.lost    = 1'b0;
            st_d.fl.lo_seen = 1'b1;
        end
        if (rd_hi_en) begin
            st_d.fl.hi_seen = 1'b1;
        end
        if (wr_en) begin
            st_d.res        = wr_data;
            st_d.fl.fresh   = 1'b1;
            // Judged from history registered before this cycle.
            st_d.fl.lost    = ~(st_q.fl.lo_seen & st_q.fl.hi_seen);
            st_d.fl.lo_seen = 1'b0;
            st_d.fl.hi_seen = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.res <= '0;
            st_q.fl  <= FLAGS_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign res_q   = st_q.res;
    assign flags_q = st_q.fl;

endmodule

// File: rtl/adcr_rdmux.sv
module adcr_rdmux
    import adcr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int RES_W  = 10,
    parameter int CH_W   = 1
) (
    input  logic [NUM_CH-1:0][RES_W-1:0] res_all,
    input  adcr_flags_t [NUM_CH-1:0]     flags_all,
    input  logic [CH_W-1:0]              rd_chan,
    input  logic                         rd_hi,
    output logic [BYTE_W-1:0]            rd_data
);

    localparam int LO_W  = RES_W - BYTE_W;
    localparam int PAD_W = BYTE_W - LO_W - 2;

    logic [NUM_CH-1:0][BYTE_W-1:0] hi_bytes;
    logic [NUM_CH-1:0][BYTE_W-1:0] lo_bytes;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_fmt
        assign hi_bytes[g] = res_all[g][RES_W-1:LO_W];
        assign lo_bytes[g] = {res_all[g][LO_W-1:0], {PAD_W{1'b0}},
                              flags_all[g].lost, flags_all[g].fresh};
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            if (rd_chan == CH_W'(i)) begin
                rd_data = rd_hi ? hi_bytes[i] : lo_bytes[i];
            end
        end
    end

endmodule

// File: rtl/adcr_result_bank.sv
module adcr_result_bank
    import adcr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int RES_W  = 10,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnv_valid,
    input  logic [CH_W-1:0]   cnv_chan,
    input  logic [RES_W-1:0]  cnv_data,
    input  logic              rd_en,
    input  logic [CH_W-1:0]   rd_chan,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data
);

    logic [NUM_CH-1:0]             wr_sel;
    logic [NUM_CH-1:0]             rd_lo_sel;
    logic [NUM_CH-1:0]             rd_hi_sel;
    logic [NUM_CH-1:0][RES_W-1:0]  res_all;
    adcr_flags_t [NUM_CH-1:0]      flags_all;

    adcr_decode #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_decode (
        .cnv_valid (cnv_valid),
        .cnv_chan  (cnv_chan),
        .rd_en     (rd_en),
        .rd_chan   (rd_chan),
        .rd_hi     (rd_hi),
        .wr_sel    (wr_sel),
        .rd_lo_sel (rd_lo_sel),
        .rd_hi_sel (rd_hi_sel)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        adcr_chan #(.RES_W(RES_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_sel[g]),
            .wr_data  (cnv_data),
            .rd_lo_en (rd_lo_sel[g]),
            .rd_hi_en (rd_hi_sel[g]),
            .res_q    (res_all[g]),
            .flags_q  (flags_all[g])
        );
    end

    adcr_rdmux #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_rdmux (
        .res_all   (res_all),
        .flags_all (flags_all),
        .rd_chan   (rd_chan),
        .rd_hi     (rd_hi),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/adcr_result_bank_chk.sv
module adcr_result_bank_chk #(
    parameter int NUM_CH = 2,
    parameter int RES_W  = 10,
    parameter int CH_W   = 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnv_valid,
    input logic [CH_W-1:0]  cnv_chan,
    input logic [RES_W-1:0] cnv_data,
    input logic             rd_en,
    input logic [CH_W-1:0]  rd_chan,
    input logic             rd_hi,
    input logic [7:0]       rd_data
);

    localparam int LO_W = RES_W - 8;

    AST_HIGH_BYTE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_valid |=> (!(rd_hi && rd_chan == $past(cnv_chan)) ||
                       rd_data == $past(cnv_data[RES_W-1:LO_W]))); // R1

    AST_LOW_BYTE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_valid |=> (!(!rd_hi && rd_chan == $past(cnv_chan)) ||
                       rd_data[7:8-LO_W] == $past(cnv_data[LO_W-1:0]))); // R2

    AST_LOW_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hi |-> rd_data[5:2] == 4'b0000); // R2

    AST_WRITE_SETS_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
        cnv_valid |=> (!(!rd_hi && rd_chan == $past(cnv_chan)) || rd_data[0])); // R3

    AST_LOW_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !rd_hi && !(cnv_valid && cnv_chan == rd_chan))
        |=> (!(!rd_hi && rd_chan == $past(rd_chan)) || rd_data[1:0] == 2'b00)); // R4

    AST_BACK_TO_BACK_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        (cnv_valid && $past(cnv_valid) && cnv_chan == $past(cnv_chan))
        |=> (!(!rd_hi && rd_chan == $past(cnv_chan)) || rd_data[1])); // R5

endmodule

bind adcr_result_bank adcr_result_bank_chk #(
    .NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv_valid (cnv_valid),
    .cnv_chan  (cnv_chan),
    .cnv_data  (cnv_data),
    .rd_en     (rd_en),
    .rd_chan   (rd_chan),
    .rd_hi     (rd_hi),
    .rd_data   (rd_data)
);

// File: tb/adcr_result_bank_tb.sv
module adcr_result_bank_tb;

    localparam int NUM_CH = 2;
    localparam int RES_W  = 10;
    localparam int CH_W   = 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cnv_valid = 1'b0;
    logic [CH_W-1:0]  cnv_chan = '0;
    logic [RES_W-1:0] cnv_data = '0;
    logic             rd_en = 1'b0;
    logic [CH_W-1:0]  rd_chan = '0;
    logic             rd_hi = 1'b0;
    logic [7:0]       rd_data;

    int checks = 0;
    int errors = 0;

    // Bench model, one entry per channel.
    int m_res   [NUM_CH];
    bit m_fresh [NUM_CH];
    bit m_lost  [NUM_CH];
    bit m_lo    [NUM_CH];
    bit m_hi    [NUM_CH];

    always #5 clk = ~clk;

    adcr_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .CH_W(CH_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cnv_valid(cnv_valid), .cnv_chan(cnv_chan),
        .cnv_data(cnv_data), .rd_en(rd_en), .rd_chan(rd_chan), .rd_hi(rd_hi),
        .rd_data(rd_data)
    );

    function automatic logic [7:0] expect_byte(int ch, bit hi);
        if (hi) return 8'((m_res[ch] / 4) % 256);
        return {2'(m_res[ch] % 4), 4'b0000, m_lost[ch], m_fresh[ch]};
    endfunction

    task automatic check(logic [7:0] act, logic [7:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: rd_data=%02h expected=%02h", tag, act, exp);
        end
    endtask

    // One cycle: drive after the falling edge, check before the rising edge,
    // then advance the model at the rising edge.
    task automatic step(bit wr, int wch, int wdat, bit re, int rch, bit rh,
                        string tag);
        bit old_lo;
        bit old_hi;
        @(negedge clk);
        cnv_valid = wr;
        cnv_chan  = CH_W'(wch);
        cnv_data  = RES_W'(wdat);
        rd_en     = re;
        rd_chan   = CH_W'(rch);
        rd_hi     = rh;
        #1;
        check(rd_data, expect_byte(rch, rh), tag);
        @(posedge clk);
        old_lo = m_lo[wch];
        old_hi = m_hi[wch];
        if (re && !rh) begin
            m_fresh[rch] = 1'b0;
            m_lost[rch]  = 1'b0;
            m_lo[rch]    = 1'b1;
        end
        if (re && rh) m_hi[rch] = 1'b1;
        if (wr) begin
            m_res[wch]   = wdat;
            m_fresh[wch] = 1'b1;
            m_lost[wch]  = !(old_lo && old_hi);
            m_lo[wch]    = 1'b0;
            m_hi[wch]    = 1'b0;
        end
    endtask

    // Operation codes: 0 idle view, 1 write, 2 low read, 3 high read,
    // 4 write with low read, 5 write with high read.
    task automatic do_op(int op, int ch, int dat);
        case (op)
            0: step(0, ch, dat, 0, ch, 0, "R10 R7");
            1: step(1, ch, dat, 0, ch, 0, "R3 R5");
            2: step(0, ch, dat, 1, ch, 0, "R4 R6 R7");
            3: step(0, ch, dat, 1, ch, 1, "R1 R7");
            4: step(1, ch, dat, 1, ch, 0, "R4 R6");
            default: step(1, ch, dat, 1, ch, 1, "R5");
        endcase
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int seed;
        for (int c = 0; c < NUM_CH; c++) begin
            m_res[c] = 0; m_fresh[c] = 0; m_lost[c] = 0;
            m_lo[c] = 1; m_hi[c] = 1;
        end
        // R8: reset state visible at the read port during reset.
        repeat (2) @(negedge clk);
        for (int c = 0; c < NUM_CH; c++) begin
            for (int h = 0; h < 2; h++) begin
                rd_chan = CH_W'(c);
                rd_hi   = h[0];
                #1;
                check(rd_data, 8'h00, "R8");
            end
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 R2: every result value through both bytes, alternating channel.
        for (int v = 0; v < (1 << RES_W); v++) begin
            step(1, v % NUM_CH, v, 0, v % NUM_CH, 0, "R3 R5");
            step(0, 0, 0, 1, v % NUM_CH, 1, "R1");
            step(0, 0, 0, 1, v % NUM_CH, 0, "R2");
        end

        // R9 and collisions: every three-step sequence over both channels.
        seed = 17;
        for (int a = 0; a < 12; a++) begin
            for (int b = 0; b < 12; b++) begin
                for (int d = 0; d < 12; d++) begin
                    seed = (seed * 37 + 11) % 1024;
                    do_op(a % 6, a / 6, seed);
                    do_op(b % 6, b / 6, (seed + 301) % 1024);
                    do_op(d % 6, d / 6, (seed + 577) % 1024);
                    for (int c = 0; c < NUM_CH; c++) begin
                        step(0, 0, 0, 0, c, 0, "R9 R10");
                        step(0, 0, 0, 0, c, 1, "R9");
                    end
                end
            end
        end

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule